// File: doc/BRIEF.md
# Supply-Supervised Reset Generator

This block produces the active-low reset that holds a baseband processor in reset until its supplies are trustworthy. It watches three flags: the system power-on state, the IO regulator's power-good flag and the memory regulator's power-good flag. Once all three are good, a programmable delay runs, and only after it has run to completion is the processor let out of reset.

A loss of either regulator, or a power-off, pulls reset low again within two clock cycles. Any such loss also throws away whatever part of the delay had been counted. The delay is set as a count of units, and each unit lasts a fixed number of clock cycles given by a parameter. All three flags come from other clock or analog domains, so each passes through a synchronizer before it is used.

Top module: `supply_reset_gen`

## Requirements
- R1: While `rst` is high, `reset_n` is driven to 0 at the next rising edge, and the delay count restarts from zero.
- R2: With `power_on`, `io_good` and `mem_good` held at 1 and `delay_setting` = D held constant, `reset_n` rises at the rising edge numbered SYNC_STAGES + 1 + D*UNIT_CYCLES, where edge 1 is the first edge that samples all three at 1 (83 edges for D = 5 with defaults SYNC_STAGES = 2 and UNIT_CYCLES = 16).
- R3: With `delay_setting` = 0, `reset_n` rises at edge SYNC_STAGES + 1 (edge 3 with defaults) after all three flags are sampled at 1.
- R4: If `io_good` is sampled at 0 at some edge, `reset_n` is 0 after the second rising edge that counts from that edge.
- R5: If `mem_good` is sampled at 0 at some edge, `reset_n` is 0 after the second rising edge that counts from that edge.
- R6: If `power_on` is sampled at 0, `reset_n` is 0 within two edges and stays 0 for as long as `power_on` is 0, whatever the regulator flags do.
- R7: A loss of any flag for even one cycle during the delay clears the count. Release then takes a full delay, counted from the edge at which all three flags are sampled at 1 again.
- R8: One good regulator flag without the other never releases reset, however long it is held.
- R9: Because of the input synchronizers, `reset_n` never rises earlier than SYNC_STAGES + 1 edges after all three flags become 1, under any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| power_on | input | 1 | System powered-on state, asynchronous |
| io_good | input | 1 | IO regulator in regulation, asynchronous |
| mem_good | input | 1 | Memory regulator in regulation, asynchronous |
| delay_setting | input | SET_W | Release delay in units of UNIT_CYCLES clocks |
| reset_n | output | 1 | Active-low processor reset, registered |

## Verification
The hardest condition to reach from the ports is a short dropout in the middle of a delay that is already running. The flag has to fall and come back while the count is partway through, and release must then take a full delay again rather than finish the remainder. The stimulus reaches this with a directed case that removes `io_good` for one cycle halfway through a long delay. It also uses random hold lengths that run up to just beyond the full delay, so dropouts land at many different counts and near the release edge itself.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef struct packed {
    logic on;
    logic io;
    logic mem;
  } supply_flags_t;

  function automatic logic flags_ok(supply_flags_t f);
    return f.on & f.io & f.mem;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] first_q,
  output logic [WIDTH-1:0] last_q
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign first_q[b] = chain[0];
      assign last_q[b]  = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int SET_W       = 8,
  parameter int UNIT_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SET_W-1:0] setting,
  output logic             done
);

  localparam int CNT_W = SET_W + $clog2(UNIT_CYCLES) + 1;

  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_q;

  assign target = CNT_W'(setting) * CNT_W'(UNIT_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (cnt_q < target) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q >= target);

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import supply_reset_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SET_W       = 8,
  parameter int UNIT_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             power_on,
  input  logic             io_good,
  input  logic             mem_good,
  input  logic [SET_W-1:0] delay_setting,
  output logic             reset_n
);

  localparam int NFLAGS = $bits(supply_flags_t);

  supply_flags_t raw_flags;
  supply_flags_t early_flags;
  supply_flags_t safe_flags;
  logic          timer_done;
  logic          reset_n_q;

  assign raw_flags = '{on: power_on, io: io_good, mem: mem_good};

  flag_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (NFLAGS)
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d      (raw_flags),
    .first_q(early_flags),
    .last_q (safe_flags)
  );

  release_timer #(
    .SET_W      (SET_W),
    .UNIT_CYCLES(UNIT_CYCLES)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .run    (flags_ok(safe_flags)),
    .setting(delay_setting),
    .done   (timer_done)
  );

  // Release needs the fully synchronized count; a fault only needs to be
  // seen by the first stage, which the output flop then retimes.
  always_ff @(posedge clk) begin
    if (rst) reset_n_q <= 1'b0;
    else     reset_n_q <= timer_done & flags_ok(early_flags);
  end

  assign reset_n = reset_n_q;

endmodule

// File: rtl/supply_reset_gen_chk.sv
module supply_reset_gen_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int SET_W       = 8,
  parameter int UNIT_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             power_on,
  input logic             io_good,
  input logic             mem_good,
  input logic [SET_W-1:0] delay_setting,
  input logic             reset_n
);

  localparam int RUN_W = SET_W + $clog2(UNIT_CYCLES) + 3;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need;

  assign need = RUN_W'(SYNC_STAGES + 1) + RUN_W'(delay_setting) * RUN_W'(UNIT_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || !(power_on && io_good && mem_good)) run_q <= '0;
    else if (run_q != '1)                          run_q <= run_q + 1'b1;
  end

  // R1
  rst_low_chk: assert property (@(posedge clk) rst |=> !reset_n);

  // R4
  io_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !io_good |-> ##2 !reset_n);

  // R5
  mem_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_good |-> ##2 !reset_n);

  // R6
  off_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !power_on |-> ##2 !reset_n);

  // R2
  release_time_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_n) |-> (run_q == need));

  // R9
  no_early_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_n) |-> (run_q >= RUN_W'(SYNC_STAGES + 1)));

endmodule

bind supply_reset_gen supply_reset_gen_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .SET_W      (SET_W),
  .UNIT_CYCLES(UNIT_CYCLES)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .power_on     (power_on),
  .io_good      (io_good),
  .mem_good     (mem_good),
  .delay_setting(delay_setting),
  .reset_n      (reset_n)
);

// File: tb/supply_reset_gen_tb_top.sv
module supply_reset_gen_tb_top;

  localparam int SYNC  = 2;
  localparam int SW    = 8;
  localparam int UNIT  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          power_on = 1'b0;
  logic          io_good = 1'b0;
  logic          mem_good = 1'b0;
  logic [SW-1:0] delay_setting = '0;
  logic          reset_n;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  int run = 0;
  logic exp_hi = 1'b0;

  always #2 clk = ~clk;

  supply_reset_gen #(.SYNC_STAGES(SYNC), .SET_W(SW), .UNIT_CYCLES(UNIT)) dut_i (
    .clk(clk), .rst(rst), .power_on(power_on), .io_good(io_good),
    .mem_good(mem_good), .delay_setting(delay_setting), .reset_n(reset_n)
  );

  function automatic int release_edges(int d);
    return SYNC + 1 + d * UNIT;
  endfunction

  // Reference: reset_n after edge k is high when the inputs had been
  // all-high for at least release_edges-1 edges up to edge k-1.
  always @(posedge clk) begin
    exp_hi <= !rst && (run >= release_edges(int'(delay_setting)) - 1);
    if (rst || !(power_on && io_good && mem_good)) run <= 0;
    else if (run < 100000) run <= run + 1;
  end

  task automatic check(string req, logic ok, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, reset_n === exp_hi, int'(reset_n), int'(exp_hi));
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(logic on, logic io, logic mem);
    @(negedge clk);
    power_on = on; io_good = io; mem_good = mem;
  endtask

  task automatic set_delay(int d);
    drive(1'b0, 1'b0, 1'b0);
    cycles(3);
    delay_setting = SW'(d);
  endtask

  task automatic measure(string req, int d);
    int n = 0;
    set_delay(d);
    drive(1'b1, 1'b1, 1'b1);
    while (reset_n !== 1'b1 && n < release_edges(d) + 10) begin
      @(negedge clk);
      n++;
    end
    check(req, n == release_edges(d), n, release_edges(d));
  endtask

  task automatic drop_check(string req, logic on, logic io, logic mem);
    drive(on, io, mem);
    cycles(2);
    check(req, reset_n === 1'b0, int'(reset_n), 0);
    cycles(5);
    check(req, reset_n === 1'b0, int'(reset_n), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_0042;
    void'($urandom(seed));
    power_on = 1'b1; io_good = 1'b1; mem_good = 1'b1;
    cycles(4);
    check("R1", reset_n === 1'b0, int'(reset_n), 0);
    drive(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    cycles(3);

    cur_req = "R3"; measure("R3", 0);
    cur_req = "R2"; measure("R2", 5);
    cur_req = "R4"; drop_check("R4", 1'b1, 1'b0, 1'b1);
    cur_req = "R2"; measure("R2", 1);
    cur_req = "R5"; drop_check("R5", 1'b1, 1'b1, 1'b0);
    cur_req = "R2"; measure("R2", 2);
    cur_req = "R6"; drop_check("R6", 1'b0, 1'b1, 1'b1);
    cycles(40);
    check("R6", reset_n === 1'b0, int'(reset_n), 0);

    // R7: one-cycle IO dropout halfway through a long delay
    cur_req = "R7";
    set_delay(4);
    drive(1'b1, 1'b1, 1'b1);
    cycles(release_edges(4) / 2);
    drive(1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b1);
    begin
      int n = 0;
      while (reset_n !== 1'b1 && n < 200) begin @(negedge clk); n++; end
      check("R7", n == release_edges(4), n, release_edges(4));
    end

    // R8: one regulator alone, held long
    cur_req = "R8";
    set_delay(0);
    drive(1'b1, 1'b1, 1'b0);
    cycles(60);
    check("R8", reset_n === 1'b0, int'(reset_n), 0);
    drive(1'b1, 1'b0, 1'b1);
    cycles(60);
    check("R8", reset_n === 1'b0, int'(reset_n), 0);

    // R1: reset in the middle of a released state
    cur_req = "R1";
    measure("R1", 0);
    @(negedge clk); rst = 1'b1;
    cycles(2);
    check("R1", reset_n === 1'b0, int'(reset_n), 0);
    @(negedge clk); rst = 1'b0;

    // R9: constrained random patterns, delays and hold lengths
    cur_req = "R9";
    for (int s = 0; s < 300; s++) begin
      int hold;
      logic [2:0] pat;
      if (s % 40 == 0) set_delay(int'($urandom_range(0, 6)));
      pat = ($urandom_range(0, 9) < 6) ? 3'b111 : 3'($urandom_range(0, 7));
      drive(pat[2], pat[1], pat[0]);
      hold = int'($urandom_range(1, release_edges(int'(delay_setting)) + 10));
      cycles(hold);
    end

    cur_req = "R2"; measure("R2", 20);
    cycles(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule